// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Byte Mover

This block copies a run of bytes between a peripheral data port and memory, with no processor help once it has been started. Software loads a memory start address and a byte count. It then writes the control register with the start bit set, together with the direction, the release policy and the interrupt enable. The engine raises a bus request and waits for a grant on a daisy-chained grant line. It then owns the shared bus and holds bus-busy for as long as it is master. In each cycle of ownership it moves one byte through a single-cycle memory port.

Two release policies are available. In cycle-stealing mode the engine gives the bus back after a fixed number of bytes, set by a parameter with a default of 4, and then requests again. In block mode it keeps the bus until the whole count has been moved. When it is not competing for the bus, the engine forwards the incoming grant to the next agent on the chain. When the count reaches zero the engine sets a done flag and, if interrupts are enabled, raises an interrupt. Software clears both by writing a one to the done bit.

Top module: `dma_chain_ctrl`

## Requirements
- R1: Register select 0 holds the memory address and select 1 holds the byte count. Both read back what was written. Select 2 reads the status: bit0 is active, bit1 is direction, bit2 is interrupt enable, bit3 is block mode, bit4 is done and bit5 is the interrupt request. All of these read zero after reset.
- R2: A control write to select 2 with bit0 (start) set, made while idle and with a nonzero count, raises `bus_req` from the next cycle. `bus_req` stays high until the engine becomes master.
- R3: `grant_out` equals `grant_in` while the engine is idle. It is low while the engine is requesting or is master.
- R4: The engine accepts a grant only on a rising edge of `grant_in` seen while `busy_in` is low. In the cycle after acceptance `busy_out` is high and `bus_req` is low. A grant that stays high, or that rises while `busy_in` is high, is not accepted.
- R5: `busy_out` stays high for the whole tenure. Exactly one byte moves in each cycle that `busy_out` is high, and memory is never accessed otherwise.
- R6: In cycle-stealing mode (control bit3 = 0) a tenure moves at most BURST bytes. The engine then releases the bus and requests again, so a count of N takes ceil(N/BURST) tenures.
- R7: In block mode (control bit3 = 1) the whole count moves in a single tenure.
- R8: Each byte increments the address by one and decrements the count by one. With direction 0 (control bit1) the byte goes from device to memory. With direction 1 it goes from memory to device.
- R9: When the count reaches zero, done is set and the interrupt is raised only if enabled (control bit2). A start with a zero count completes at once without a bus request.
- R10: A control write with bit4 set clears done and the interrupt. A control write with bit4 clear leaves them unchanged.
- R11: While active, writes to the address, the count and the configuration, and any new start, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_sel` |
| bus_req | output | 1 | Bus request |
| grant_in | input | 1 | Grant from the upstream agent on the chain |
| grant_out | output | 1 | Grant forwarded to the downstream agent |
| busy_in | input | 1 | Bus-busy driven by other masters |
| busy_out | output | 1 | Bus-busy driven while this engine is master |
| mem_en | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | Memory write (device to memory) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle |
| dev_re | output | 1 | Pops one byte from the device |
| dev_rdata | input | DATA_W | Byte offered by the device |
| dev_we | output | 1 | Pushes one byte to the device |
| dev_wdata | output | DATA_W | Byte sent to the device |
| irq | output | 1 | Completion interrupt request |

## Verification
The assertions assume that the memory answers a read in the same cycle and that the device can always supply or take a byte, so no transfer stall is ever expected. They also assume that `grant_in` comes only from an upstream agent that honours bus-busy. The bench's grant driver raises `grant_in` for one cycle only while `bus_req` is high. It holds `busy_in` low except in one directed case, which checks that a grant rising under a foreign bus-busy is refused. All register writes are made in whole cycles, away from the clock edge.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2
  } bus_state_t;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  // control write / status read bit positions
  localparam int B_START  = 0;  // write: start
  localparam int B_ACTIVE = 0;  // read: engine busy
  localparam int B_DIR    = 1;
  localparam int B_IEN    = 2;
  localparam int B_BLOCK  = 3;
  localparam int B_DONE   = 4;
  localparam int B_IRQ    = 5;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              active,
  input  logic              fire,
  input  logic              last,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              dir,
  output logic              block,
  output logic              start_go,
  output logic              irq
);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic dir_q, blk_q, ien_q, done_q, irq_q;

  logic ctrl_wr, cfg_wr, start_req, zero_start, finish_evt, ien_next;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  assign ctrl_wr    = reg_we && (reg_sel == SEL_CTRL);
  assign cfg_wr     = ctrl_wr && !active;
  assign start_req  = cfg_wr && reg_wdata[B_START];
  assign start_go   = start_req && (cnt_q != '0);
  assign zero_start = start_req && (cnt_q == '0);
  assign finish_evt = last || zero_start;
  assign ien_next   = cfg_wr ? reg_wdata[B_IEN] : ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      blk_q  <= 1'b0;
      ien_q  <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_we && (reg_sel == SEL_ADDR) && !active) addr_q <= reg_wdata[ADDR_W-1:0];
      else if (fire)                                  addr_q <= addr_step(addr_q);
      if (reg_we && (reg_sel == SEL_COUNT) && !active) cnt_q <= reg_wdata[CNT_W-1:0];
      else if (fire)                                   cnt_q <= cnt_step(cnt_q);
      if (cfg_wr) begin
        dir_q <= reg_wdata[B_DIR];
        blk_q <= reg_wdata[B_BLOCK];
        ien_q <= reg_wdata[B_IEN];
      end
      if (finish_evt) begin
        done_q <= 1'b1;
        irq_q  <= ien_next;
      end else if (ctrl_wr && reg_wdata[B_DONE]) begin
        done_q <= 1'b0;
        irq_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_ADDR:  reg_rdata[ADDR_W-1:0] = addr_q;
      SEL_COUNT: reg_rdata[CNT_W-1:0]  = cnt_q;
      SEL_CTRL: begin
        reg_rdata[B_ACTIVE] = active;
        reg_rdata[B_DIR]    = dir_q;
        reg_rdata[B_IEN]    = ien_q;
        reg_rdata[B_BLOCK]  = blk_q;
        reg_rdata[B_DONE]   = done_q;
        reg_rdata[B_IRQ]    = irq_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign cur_addr  = addr_q;
  assign cur_count = cnt_q;
  assign dir       = dir_q;
  assign block     = blk_q;
  assign irq       = irq_q;

  // R8: every moved byte steps the count and the address by one
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
  // R9: done only ever appears with the count exhausted
  p_done_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (cnt_q == '0));

endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic release_req,
  input  logic last,
  input  logic grant_in,
  input  logic busy_in,
  output logic bus_req,
  output logic busy_out,
  output logic grant_out,
  output logic master,
  output logic active
);

  bus_state_t state_q, state_d;
  logic grant_prev_q;
  logic grant_take;

  assign grant_take = (state_q == ST_REQ) && grant_in && !grant_prev_q && !busy_in;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_REQ;
      ST_REQ:  if (grant_take) state_d = ST_OWN;
      ST_OWN: begin
        if (last)             state_d = ST_IDLE;
        else if (release_req) state_d = ST_REQ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      grant_prev_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      grant_prev_q <= grant_in;
    end
  end

  assign bus_req   = (state_q == ST_REQ);
  assign busy_out  = (state_q == ST_OWN);
  assign grant_out = grant_in && (state_q == ST_IDLE);
  assign master    = busy_out;
  assign active    = (state_q != ST_IDLE);

  // R2: a request is held until mastership is reached
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> (bus_req || busy_out));
  // R4: mastership only follows a fresh grant edge under a free bus
  p_grant_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_out) |-> ($past(grant_in) && !$past(grant_in, 2) && !$past(busy_in)));
  // R5: busy and request are never raised together
  p_busy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_out |-> !bus_req);

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              dir,
  input  logic              block,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_count,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fire,
  output logic              last,
  output logic              release_req,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              dev_re,
  output logic              dev_we,
  output logic [DATA_W-1:0] dev_wdata
);

  localparam int BW = $clog2(BURST + 1);

  logic [BW-1:0] burst_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !master) burst_q <= '0;
    else if (fire)         burst_q <= burst_q + BW'(1);
  end

  assign fire        = master;
  assign last        = fire && (cur_count == CNT_W'(1));
  assign release_req = fire && !block && (burst_q == BW'(BURST - 1));

  assign mem_en    = fire;
  assign mem_we    = fire && !dir;
  assign mem_addr  = cur_addr;
  assign mem_wdata = dev_rdata;
  assign dev_re    = fire && !dir;
  assign dev_we    = fire && dir;
  assign dev_wdata = mem_rdata;

  // R6: a cycle-stealing tenure never exceeds BURST bytes
  p_burst_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !block) |-> (burst_q < BW'(BURST)));
  // R5: a byte is only moved while some count remains
  p_move_needs_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (cur_count != '0));

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              bus_req,
  input  logic              grant_in,
  output logic              grant_out,
  input  logic              busy_in,
  output logic              busy_out,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dev_re,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              dev_we,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              irq
);

  logic              active, master, fire, last, release_req, start_go;
  logic              dir, block;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_count;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk, .rst_n, .reg_sel, .reg_we, .reg_wdata, .reg_rdata,
    .active, .fire, .last, .cur_addr, .cur_count, .dir, .block,
    .start_go, .irq
  );

  dma_arb u_arb (
    .clk, .rst_n, .go(start_go), .release_req, .last,
    .grant_in, .busy_in, .bus_req, .busy_out, .grant_out,
    .master, .active
  );

  dma_xfer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST(BURST)) u_xfer (
    .clk, .rst_n, .master, .dir, .block, .cur_addr, .cur_count,
    .dev_rdata, .mem_rdata, .fire, .last, .release_req,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .dev_re, .dev_we, .dev_wdata
  );

  // R5: memory is touched only under this engine's own bus-busy
  p_access_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (busy_out && !bus_req));

endmodule

// File: tb/test_dma_chain_ctrl.sv
module test_dma_chain_ctrl;

  localparam int PERIOD = 10;
  localparam int BURST  = 4;
  localparam logic [1:0] S_ADDR = 2'd0, S_CNT = 2'd1, S_CTRL = 2'd2;

  // vector: [18] dir, [17] block, [16] irq enable, [15:8] count, [7:0] address
  localparam logic [18:0] VECS [6] = '{
    {1'b0, 1'b0, 1'b1, 8'd10, 8'h10},
    {1'b1, 1'b0, 1'b1, 8'd4,  8'h40},
    {1'b0, 1'b1, 1'b0, 8'd9,  8'h80},
    {1'b1, 1'b1, 1'b1, 8'd1,  8'h20},
    {1'b1, 1'b0, 1'b0, 8'd5,  8'hC0},
    {1'b0, 1'b0, 1'b1, 8'd8,  8'h30}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic bus_req, grant_in = 1'b0, grant_out, busy_in = 1'b0, busy_out;
  logic mem_en, mem_we, dev_re, dev_we, irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, dev_rdata, dev_wdata;

  int checks = 0, fails = 0;
  int dev_idx = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction
  function automatic logic [7:0] minit(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  assign mem_rdata = minit(mem_addr[7:0]);
  assign dev_rdata = pat(dev_idx);

  dma_chain_ctrl i_dma_chain_ctrl (
    .clk, .rst_n, .reg_sel, .reg_we, .reg_wdata, .reg_rdata,
    .bus_req, .grant_in, .grant_out, .busy_in, .busy_out,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .dev_re, .dev_rdata, .dev_we, .dev_wdata, .irq
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  // runs from a negedge until the engine is idle; grant driver included
  task automatic run(input logic dir, input logic [15:0] base,
                     output int moved, output int tenures, output int errs);
    logic prev_busy = 1'b0;
    logic [15:0] exp_addr = base;
    moved = 0; tenures = 0; errs = 0;
    for (int c = 0; c < 2000; c++) begin
      if (!bus_req && !busy_out) break;
      if (busy_out && !prev_busy) tenures++;
      prev_busy = busy_out;
      if (mem_en) begin
        if (mem_addr !== exp_addr) errs++;
        if (dir) begin
          if (!dev_we || dev_re || mem_we || dev_wdata !== minit(mem_addr[7:0])) errs++;
        end else begin
          if (!mem_we || !dev_re || dev_we || mem_wdata !== pat(moved)) errs++;
        end
        moved++;
        exp_addr++;
      end
      if (dev_re) dev_idx++;
      grant_in = bus_req && !grant_in;
      @(negedge clk);
    end
    grant_in = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int moved, ten, errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R1)
    chk("R1 reset bus_req", 32'(bus_req), 0);
    chk("R1 reset busy_out", 32'(busy_out), 0);
    chk("R1 reset irq", 32'(irq), 0);
    rd(S_CTRL, v); chk("R1 reset status", 32'(v), 0);
    rd(S_ADDR, v); chk("R1 reset address", 32'(v), 0);

    // register readback (R1)
    wr(S_ADDR, 16'h1234); wr(S_CNT, 16'h0005);
    rd(S_ADDR, v); chk("R1 address readback", 32'(v), 32'h1234);
    rd(S_CNT, v);  chk("R1 count readback", 32'(v), 32'h0005);

    // grant passes through while idle (R3)
    grant_in = 1'b1; #1; chk("R3 idle pass high", 32'(grant_out), 1);
    grant_in = 1'b0; #1; chk("R3 idle pass low", 32'(grant_out), 0);

    // table of transfers
    foreach (VECS[k]) begin
      logic d, b, ie;
      logic [7:0] cnt, base;
      int exp_ten;
      {d, b, ie, cnt, base} = VECS[k];
      exp_ten = b ? 1 : (int'(cnt) + BURST - 1) / BURST;
      dev_idx = 0;
      wr(S_ADDR, {8'h00, base});
      wr(S_CNT, {8'h00, cnt});
      wr(S_CTRL, 16'((32'(b) << 3) | (32'(ie) << 2) | (32'(d) << 1) | 1));
      chk("R2 request after start", 32'(bus_req), 1);
      run(d, {8'h00, base}, moved, ten, errs);
      chk("R5 bytes moved", 32'(moved), 32'(cnt));
      chk(b ? "R7 tenures block" : "R6 tenures steal", 32'(ten), 32'(exp_ten));
      chk("R8 data and address sequence errors", 32'(errs), 0);
      rd(S_ADDR, v); chk("R8 final address", 32'(v), 32'(base) + 32'(cnt));
      rd(S_CNT, v);  chk("R8 final count", 32'(v), 0);
      rd(S_CTRL, v);
      chk("R9 status at completion", 32'(v),
          (32'(ie) << 5) | 32'h10 | (32'(b) << 3) | (32'(ie) << 2) | (32'(d) << 1));
      chk("R9 irq follows enable", 32'(irq), 32'(ie));
      wr(S_CTRL, 16'h0010);
      rd(S_CTRL, v); chk("R10 done cleared", 32'(v), 0);
      chk("R10 irq cleared", 32'(irq), 0);
    end

    // zero-count start completes at once (R9), and done-bit 0 write keeps done (R10)
    wr(S_CNT, 16'h0000);
    wr(S_CTRL, 16'h0005);
    chk("R9 zero count no request", 32'(bus_req), 0);
    rd(S_CTRL, v); chk("R9 zero count status", 32'(v), 32'h34);
    chk("R9 zero count irq", 32'(irq), 1);
    wr(S_CTRL, 16'h0004);
    rd(S_CTRL, v); chk("R10 done kept on bit4 clear", 32'(v), 32'h34);
    wr(S_CTRL, 16'h0010);
    rd(S_CTRL, v); chk("R10 done cleared again", 32'(v), 0);

    // grant edge rules, writes while active ignored
    dev_idx = 0;
    wr(S_ADDR, 16'h0050); wr(S_CNT, 16'h0003);
    wr(S_CTRL, 16'h0001);
    chk("R2 request raised", 32'(bus_req), 1);
    grant_in = 1'b1; busy_in = 1'b1; #1;
    chk("R3 no pass while requesting", 32'(grant_out), 0);
    @(negedge clk);
    chk("R4 refused under foreign busy", 32'(busy_out), 0);
    chk("R4 still requesting", 32'(bus_req), 1);
    busy_in = 1'b0;
    wr(S_ADDR, 16'h0099);
    chk("R4 held grant level not accepted", 32'(busy_out), 0);
    wr(S_CNT, 16'h0077);
    wr(S_CTRL, 16'h000F);
    grant_in = 1'b0;
    @(negedge clk);
    grant_in = 1'b1;
    @(negedge clk);
    chk("R4 master after fresh edge", 32'(busy_out), 1);
    chk("R4 request dropped", 32'(bus_req), 0);
    chk("R3 no pass while master", 32'(grant_out), 0);
    grant_in = 1'b0;
    run(1'b0, 16'h0050, moved, ten, errs);
    chk("R11 count write ignored", 32'(moved), 3);
    chk("R11 direction write ignored", 32'(errs), 0);
    rd(S_ADDR, v); chk("R11 address write ignored", 32'(v), 32'h53);
    rd(S_CTRL, v); chk("R11 config write ignored", 32'(v), 32'h10);
    wr(S_CTRL, 16'h0010);

    summary();
    $finish;
  end

endmodule